// File: doc/BRIEF.md
# Byte-Lane Static Memory Controller

This block sits between a synchronous host port and an external asynchronous static memory that has a 16-bit data path split into a low and a high byte lane. The host offers one request at a time: a direction bit, a word address, 16 bits of write data and a two-bit lane mask. The controller turns each request into a pin-level cycle. It drives chip select, output enable, write strobe and the two active-low lane selects, and it controls a split data bus whose drive enable switches the pad between output and high impedance. A read returns the selected lanes of the word with a one-cycle completion strobe. A write returns the same strobe once the memory has latched the data.

Every pin comes straight from a flop. The length of each phase is a whole number of clock cycles. It is found by rounding the memory's nanosecond limits, given here as picosecond parameters, up against a clock-period parameter. After reset the controller waits for a power-up interval, set as a cycle count, before it offers `ready`. It accepts work only while idle.

The state machine has seven states. PWRUP goes to IDLE when the power-up count expires. IDLE goes to WSETUP on an accepted write, or to READ on an accepted read. WSETUP goes to WPULSE after one cycle. WPULSE goes to WHOLD when its pulse count ends. WHOLD goes to DONE after one cycle. READ goes to DONE when its access count ends. DONE goes back to IDLE after one cycle.

Top module: `sram_ctl`

## Requirements
- R1: From reset until `ready` first rises, chip select, output enable, write strobe and both lane selects are high, and the data bus is not driven. `ready` rises exactly PWRUP_CYC clock edges after reset is released.
- R2: `ready` is high only in the idle state, and while it is high chip select is high. A request presented while `ready` is low is ignored: it never reaches the memory and never produces a completion.
- R3: A write drives chip select low with output enable high for 1 setup cycle, WP_CYC cycles with the write strobe low, and 1 hold cycle. With an 8 ns clock WP_CYC is 1. Address, lane selects and write data stay stable and driven for all of these cycles.
- R4: Mask bit 0 enables the low lane (data bits 7:0, select `mem_lb_n`). Mask bit 1 enables the high lane (bits 15:8, select `mem_ub_n`). A write changes only the enabled lanes, and a write with mask 00 changes nothing.
- R5: A read drives chip select and output enable low with the write strobe high for RD_CYC cycles, which is 2 with an 8 ns clock, and never drives the data bus.
- R6: Read data is sampled on the last read cycle. In `rsp_rdata`, lanes whose mask bit is clear read as zero.
- R7: `rsp_done` is a single-cycle pulse. With default timing and an 8 ns clock it is seen 4 cycles after a write is accepted and 3 cycles after a read is accepted.
- R8: The data bus is never driven while output enable is low. The cycle before output enable falls always has the bus released, including when a read directly follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 low lane, bit 1 high lane |
| ready | output | 1 | Idle and powered up, a request is taken this cycle |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Low lane select, active low |
| mem_ub_n | output | 1 | High lane select, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The critical coincidence is the end of a write and the start of a read. When a read request waits for `ready` right behind a write, the write's bus release and the read's output-enable assertion fall only the DONE and IDLE cycles apart. A collision there would be a bus fight. The bench issues back-to-back write then read pairs to the same address. A monitor checks every cycle that the bus was released in the cycle before output enable fell, and the read-back value confirms that the write was latched before the read started.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_READ,
        ST_DONE
    } st_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
    parameter int CYC = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ok
);
    localparam int W = $clog2(CYC + 1);

    logic [W-1:0] cnt;

    assign ok = (cnt == W'(CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!ok)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         last
);
    logic [W-1:0] cnt;

    assign last = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (!last)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int CLK_PS    = 8000,
    parameter int PWRUP_CYC = 125000,
    parameter int T_RC_PS   = 10000,
    parameter int T_AA_PS   = 10000,
    parameter int T_DOE_PS  = 5000,
    parameter int T_WC_PS   = 10000,
    parameter int T_PWE_PS  = 7000,
    parameter int T_SD_PS   = 5500,
    parameter int T_AW_PS   = 7000,
    parameter int T_BW_PS   = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              ready,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_i
);
    // Phase lengths in cycles, each rounded up from the memory limits.
    localparam int RD_CYC = imax(1, cdiv(imax(imax(T_RC_PS, T_AA_PS), T_DOE_PS), CLK_PS));
    localparam int WP_MIN = cdiv(imax(imax(T_PWE_PS, T_SD_PS), imax(T_AW_PS, T_BW_PS)), CLK_PS);
    localparam int WP_CYC = imax(1, imax(WP_MIN, cdiv(T_WC_PS, CLK_PS) - 2));
    localparam int PH_W   = $clog2(imax(RD_CYC, WP_CYC) + 1);

    st_e st, st_nxt;

    logic              pwr_ok, ph_last, ph_load, accept;
    logic [PH_W-1:0]   ph_val;
    logic [1:0]        be_q, be_src;
    logic              ce_d, oe_d, we_d, lb_d, ub_d, dqoe_d;

    sram_pwrup_timer #(.CYC(PWRUP_CYC)) u_pwr (
        .clk  (clk),
        .rst_n(rst_n),
        .ok   (pwr_ok)
    );

    sram_phase_cnt #(.W(PH_W)) u_ph (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ph_load),
        .val  (ph_val),
        .last (ph_last)
    );

    assign ready  = (st == ST_IDLE);
    assign accept = ready && req_valid;
    assign be_src = accept ? req_be : be_q;

    assign ph_load = (st_nxt != st) && (st_nxt == ST_WPULSE || st_nxt == ST_READ);
    assign ph_val  = (st_nxt == ST_READ) ? PH_W'(RD_CYC - 1) : PH_W'(WP_CYC - 1);

    // Next-state decode
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_PWRUP:  if (pwr_ok) st_nxt = ST_IDLE;
            ST_IDLE:   if (req_valid) st_nxt = req_we ? ST_WSETUP : ST_READ;
            ST_WSETUP: st_nxt = ST_WPULSE;
            ST_WPULSE: if (ph_last) st_nxt = ST_WHOLD;
            ST_WHOLD:  st_nxt = ST_DONE;
            ST_READ:   if (ph_last) st_nxt = ST_DONE;
            ST_DONE:   st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_PWRUP;
        else
            st <= st_nxt;
    end

    // Pin values for the state being entered
    always_comb begin
        ce_d   = 1'b1;
        oe_d   = 1'b1;
        we_d   = 1'b1;
        lb_d   = 1'b1;
        ub_d   = 1'b1;
        dqoe_d = 1'b0;
        unique case (st_nxt)
            ST_WSETUP, ST_WPULSE, ST_WHOLD: begin
                ce_d   = 1'b0;
                we_d   = (st_nxt != ST_WPULSE);
                lb_d   = !be_src[0];
                ub_d   = !be_src[1];
                dqoe_d = 1'b1;
            end
            ST_READ: begin
                ce_d = 1'b0;
                oe_d = 1'b0;
                lb_d = !be_src[0];
                ub_d = !be_src[1];
            end
            default: ;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            be_q      <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            mem_ce_n  <= ce_d;
            mem_oe_n  <= oe_d;
            mem_we_n  <= we_d;
            mem_lb_n  <= lb_d;
            mem_ub_n  <= ub_d;
            mem_dq_oe <= dqoe_d;
            rsp_done  <= (st_nxt == ST_DONE);
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
                be_q     <= req_be;
            end
            if (st == ST_READ && ph_last)
                rsp_rdata <= mem_dq_i & {{8{be_q[1]}}, {8{be_q[0]}}};
        end
    end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input logic        rsp_done,
    input logic        mem_ce_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic        mem_lb_n,
    input logic        mem_ub_n,
    input logic [15:0] mem_dq_o,
    input logic        mem_dq_oe,
    input logic [19:0] mem_addr
);
    logic seen_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_rdy <= 1'b0;
        else if (ready)
            seen_rdy <= 1'b1;
    end

    // R1: pins quiet until powered up
    a_r1_quiet_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_rdy |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

    // R2: idle means deselected
    a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_ce_n);

    // R3: strobe only inside a selected, driven cycle
    a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    // R3: data still driven and unchanged after the strobe rises
    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (mem_dq_oe && $stable(mem_dq_o)));

    // R3: address and lane selects frozen during a selected cycle
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    // R5: reads never drive the bus
    a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

    // R7: completion lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: a released cycle precedes output enable
    a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

bind sram_ctl sram_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .rsp_done (rsp_done),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .mem_addr (20'(mem_addr))
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
    localparam int PWR = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o, mem_dq_i;

    int checks = 0, fails = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    sram_ctl #(.ADDR_W(20), .CLK_PS(8000), .PWRUP_CYC(PWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: 16 words, write latched on rising strobe
    logic [15:0] mem [16] = '{default: 16'h0000};
    always @(posedge mem_we_n)
        if (mem_ce_n === 1'b0) begin
            if (!mem_lb_n) mem[mem_addr[3:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_ub_n) mem[mem_addr[3:0]][15:8] <= mem_dq_o[15:8];
        end
    wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_i[7:0]  = (rd_on && !mem_lb_n) ? mem[mem_addr[3:0]][7:0]  : 8'hEE;
    assign mem_dq_i[15:8] = (rd_on && !mem_ub_n) ? mem[mem_addr[3:0]][15:8] : 8'hEE;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Pin monitors
    bit seen_rdy = 0;
    int wlow = 0, rlow = 0;
    logic prev_oe_n = 1'b1, prev_dqoe = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (ready) seen_rdy = 1;
        if (!seen_rdy && (mem_ce_n !== 1'b1 || mem_dq_oe !== 1'b0))
            chk("R1 quiet before ready", {mem_ce_n, mem_dq_oe}, 32'h2);
        if (ready && mem_ce_n !== 1'b1) chk("R2 idle deselect", mem_ce_n, 1);
        if (!mem_we_n) begin
            wlow++;
            if (mem_dq_oe !== 1'b1 || mem_oe_n !== 1'b1) chk("R3 strobe with drive", {mem_dq_oe, mem_oe_n}, 32'h3);
        end else if (wlow != 0) begin
            chk("R3 strobe width", wlow, 1);
            chk("R3 hold cycle driven", mem_dq_oe, 1);
            wlow = 0;
        end
        if (!mem_oe_n) begin
            rlow++;
            if (mem_dq_oe !== 1'b0) chk("R8 no drive under OE", mem_dq_oe, 0);
            if (prev_oe_n && prev_dqoe) chk("R8 release before OE", prev_dqoe, 0);
        end else if (rlow != 0) begin
            chk("R5 read length", rlow, 2);
            rlow = 0;
        end
        prev_oe_n = mem_oe_n;
        prev_dqoe = mem_dq_oe;
    end

    // Vector: we, be[1:0], addr[3:0], wdata, expected read
    localparam int NV = 15;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 2'b11, 4'd1,  16'hA5C3, 16'h0000},
        {1'b0, 2'b11, 4'd1,  16'h0000, 16'hA5C3},
        {1'b1, 2'b01, 4'd2,  16'h1234, 16'h0000},
        {1'b0, 2'b11, 4'd2,  16'h0000, 16'h0034},
        {1'b1, 2'b10, 4'd2,  16'hFF77, 16'h0000},
        {1'b0, 2'b11, 4'd2,  16'h0000, 16'hFF34},
        {1'b0, 2'b01, 4'd2,  16'h0000, 16'h0034},
        {1'b0, 2'b10, 4'd2,  16'h0000, 16'hFF00},
        {1'b1, 2'b11, 4'd15, 16'hFFFF, 16'h0000},
        {1'b0, 2'b11, 4'd15, 16'h0000, 16'hFFFF},
        {1'b0, 2'b11, 4'd1,  16'h0000, 16'hA5C3},
        {1'b1, 2'b00, 4'd1,  16'h0000, 16'h0000},
        {1'b0, 2'b11, 4'd1,  16'h0000, 16'hA5C3},
        {1'b0, 2'b00, 4'd1,  16'h0000, 16'h0000},
        {1'b0, 2'b11, 4'd3,  16'h0000, 16'h0000}
    };

    task automatic do_req(input logic we, input logic [1:0] be, input logic [3:0] a,
                          input logic [15:0] wd, input logic [15:0] exp);
        int n = 0;
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_be = be;
        req_addr = 20'(a); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R7 latency", n, we ? 4 : 3);
        @(negedge clk);
        chk("R7 single pulse", rsp_done, 0);
        if (!we) chk("R4 R6 read data", rsp_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 32'h3E);
        rst_n = 1'b1;
        // R2: write of 0xDEAD to word 3 while powering up must be ignored
        req_valid = 1'b1; req_we = 1'b1; req_be = 2'b11;
        req_addr = 20'd3; req_wdata = 16'hDEAD;
        while (!ready && n < PWR + 10) begin
            @(posedge clk);
            n++;
            if (n == 10) begin
                #1 req_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R1 power-up length", n, PWR);
        repeat (5) @(negedge clk) chk("R2 no stray done", rsp_done, 0);
        chk("R2 idle deselected", mem_ce_n, 1);
        for (int i = 0; i < NV; i++)
            do_req(VEC[i][38], VEC[i][37:36], VEC[i][35:32], VEC[i][31:16], VEC[i][15:0]);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule